// File: doc/BRIEF.md
# Dual Interval Timer with Decade Prescale

This block holds two 16-bit up-counting interval timers that run from a slow external timer clock. That clock has no phase relation to the system clock, so it is brought through a two-flop synchronizer. An edge detector then turns each rising edge into a single-cycle tick. The first timer takes one step per tick. The second timer sits behind a divide-by-ten prescaler and takes one step for every ten ticks.

Each timer accepts start, halt and load strobes, each one system clock wide, and a shared 16-bit write bus supplies the load value. Each timer's current value is always visible on its own read-out port. When a timer wraps, it raises a one-cycle request on its own bit of a 16-bit interrupt request vector, which the pending-interrupt logic sits behind. An active-low freeze input stops all counting. Command address decoding is done outside the block.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counts read 0000, both timers are halted, the prescaler is at zero and the request vector is all zero.
- R2: A rising timer-clock edge first sampled high at system clock edge n advances a running, unfrozen timer A by one at clock edge n+2. Each timer-clock period gives exactly one step.
- R3: A start strobe sets a timer running and a halt strobe stops it. Either one takes effect for ticks from the following cycle, and halt wins when both arrive in the same cycle.
- R4: Timer A wraps from FFFF to 0000 and keeps counting. In the cycle where 0000 first appears, request bit 7 is high for exactly one cycle.
- R5: Timer B advances by one on every tenth qualifying tick. A qualifying tick is one that arrives while B is running and the freeze input is high.
- R6: Timer B wraps from FFFF to 0000 and keeps counting. In the cycle where 0000 first appears, request bit 9 is high for exactly one cycle.
- R7: Loading timer B clears the prescaler, so B's next step comes ten qualifying ticks after the load.
- R8: Only bits 7 and 9 of the request vector are ever set, and each one is set only for the single cycle of a wrap.
- R9: While the freeze input is low, neither counter and not the prescaler move on ticks. Start, halt and load still take effect.
- R10: A load strobe puts the write-bus value on the count output in the next cycle. It overrides any step in that cycle and leaves the running state unchanged.
- R11: The prescaler advances only while timer B is running, and it keeps its partial count across a halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tclk_i | input | 1 | Asynchronous slow timer clock |
| freeze_ni | input | 1 | Active-low counting freeze for both timers |
| a_start_i | input | 1 | Start strobe, timer A |
| a_halt_i | input | 1 | Halt strobe, timer A |
| a_load_i | input | 1 | Load strobe, timer A |
| b_start_i | input | 1 | Start strobe, timer B |
| b_halt_i | input | 1 | Halt strobe, timer B |
| b_load_i | input | 1 | Load strobe, timer B |
| wdata_i | input | 16 | Load value for either timer |
| a_count_o | output | 16 | Current value of timer A |
| b_count_o | output | 16 | Current value of timer B |
| irq_req_o | output | 16 | Overflow requests: bit 7 for timer A, bit 9 for timer B |

## Verification
The bench loads timer B while the prescaler holds a partial count. A design that kept the stale prescale would step B early, after fewer than ten ticks. It halts B partway through a decade and later restarts it. A prescaler that reset on halt, or kept advancing while halted, would give the wrong count. The bench loads both timers near FFFF to reach the wraps. A pulse that lasted more than one cycle, landed on the wrong request bit, or came with a count other than 0000 is caught. It also holds the freeze input low across several ticks, and it issues start and halt in the same cycle to confirm that halt wins.

// File: rtl/timer_pkg.sv
package timer_pkg;
    // Command strobes for one interval timer, one system clock wide.
    typedef struct packed {
        logic start;
        logic halt;
        logic load;
    } tmr_cmd_t;
endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic tick_o
);
    // chain_q[0..STAGES-1]: synchronizer, chain_q[STAGES]: edge history
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign tick_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/decade_prescale.sv
module decade_prescale #(
    parameter int DIV = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic adv_i,
    output logic carry_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)            cnt_d = '0;
        else if (adv_i) begin
            if (cnt_q == LAST) cnt_d = '0;
            else               cnt_d = cnt_q + PW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign carry_o = adv_i & ~clr_i & (cnt_q == LAST);
endmodule

// File: rtl/interval_counter.sv
module interval_counter
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  tmr_cmd_t     cmd_i,
    input  logic [W-1:0] wdata_i,
    input  logic         step_i,
    output logic [W-1:0] count_o,
    output logic         run_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         run;
        logic         wrap;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        if (cmd_i.halt)       st_d.run = 1'b0;
        else if (cmd_i.start) st_d.run = 1'b1;
        if (cmd_i.load) begin
            st_d.cnt = wdata_i;
        end else if (st_q.run && step_i) begin
            st_d.cnt  = st_q.cnt + W'(1);
            st_d.wrap = (st_q.cnt == ALL_ONES);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign run_o   = st_q.run;
    assign wrap_o  = st_q.wrap;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int B_DIV       = 10,
    parameter int SYNC_STAGES = 2,
    parameter int IRQ_W       = 16,
    parameter int A_IRQ_BIT   = 7,
    parameter int B_IRQ_BIT   = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tclk_i,
    input  logic             freeze_ni,
    input  logic             a_start_i,
    input  logic             a_halt_i,
    input  logic             a_load_i,
    input  logic             b_start_i,
    input  logic             b_halt_i,
    input  logic             b_load_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] a_count_o,
    output logic [CNT_W-1:0] b_count_o,
    output logic [IRQ_W-1:0] irq_req_o
);
    localparam int NUM_TMR = 2;

    logic                 tick;
    logic                 qual_tick;
    logic                 b_carry;
    tmr_cmd_t [NUM_TMR-1:0] cmd_v;
    logic [NUM_TMR-1:0]   run_v;
    logic [NUM_TMR-1:0]   wrap_v;
    logic [CNT_W-1:0]     cnt_v [NUM_TMR];

    tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (tclk_i),
        .tick_o  (tick)
    );

    assign qual_tick = tick & freeze_ni;

    decade_prescale #(.DIV(B_DIV)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (b_load_i),
        .adv_i   (qual_tick & run_v[1]),
        .carry_o (b_carry)
    );

    assign cmd_v[0] = '{start: a_start_i, halt: a_halt_i, load: a_load_i};
    assign cmd_v[1] = '{start: b_start_i, halt: b_halt_i, load: b_load_i};

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        logic step;
        if (i == 0) begin : g_direct
            assign step = qual_tick;
        end else begin : g_scaled
            assign step = b_carry;
        end
        interval_counter #(.W(CNT_W)) u_cnt (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .cmd_i   (cmd_v[i]),
            .wdata_i (wdata_i),
            .step_i  (step),
            .count_o (cnt_v[i]),
            .run_o   (run_v[i]),
            .wrap_o  (wrap_v[i])
        );
    end

    always_comb begin
        irq_req_o            = '0;
        irq_req_o[A_IRQ_BIT] = wrap_v[0];
        irq_req_o[B_IRQ_BIT] = wrap_v[1];
    end

    assign a_count_o = cnt_v[0];
    assign b_count_o = cnt_v[1];
endmodule

// File: rtl/dual_interval_timer_checker.sv
module dual_interval_timer_checker #(
    parameter int CNT_W     = 16,
    parameter int IRQ_W     = 16,
    parameter int A_IRQ_BIT = 7,
    parameter int B_IRQ_BIT = 9
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             freeze_ni,
    input logic             a_halt_i,
    input logic             a_load_i,
    input logic             b_load_i,
    input logic [CNT_W-1:0] wdata_i,
    input logic [CNT_W-1:0] a_count_o,
    input logic [CNT_W-1:0] b_count_o,
    input logic [IRQ_W-1:0] irq_req_o
);
    localparam logic [IRQ_W-1:0] OK_BITS =
        (IRQ_W'(1) << A_IRQ_BIT) | (IRQ_W'(1) << B_IRQ_BIT);
    localparam logic [CNT_W-1:0] TOP = '1;

    p_step_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !a_load_i |=> (a_count_o == $past(a_count_o) ||
                       a_count_o == CNT_W'($past(a_count_o) + 1)));

    p_halt_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        a_halt_i ##1 !a_load_i |=> $stable(a_count_o));

    p_wrap_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_req_o[A_IRQ_BIT] |-> (a_count_o == '0 && $past(a_count_o) == TOP));

    p_step_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !b_load_i |=> (b_count_o == $past(b_count_o) ||
                       b_count_o == CNT_W'($past(b_count_o) + 1)));

    p_wrap_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_req_o[B_IRQ_BIT] |-> (b_count_o == '0 && $past(b_count_o) == TOP));

    p_req_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_req_o & ~OK_BITS) == '0);

    p_single_a_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_req_o[A_IRQ_BIT] |=> !irq_req_o[A_IRQ_BIT]);

    p_freeze_a_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!freeze_ni && !a_load_i) |=> $stable(a_count_o));

    p_freeze_b_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!freeze_ni && !b_load_i) |=> $stable(b_count_o));

    p_load_a_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        a_load_i |=> a_count_o == $past(wdata_i));

    p_load_b_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        b_load_i |=> b_count_o == $past(wdata_i));
endmodule

bind dual_interval_timer dual_interval_timer_checker #(
    .CNT_W(CNT_W), .IRQ_W(IRQ_W), .A_IRQ_BIT(A_IRQ_BIT), .B_IRQ_BIT(B_IRQ_BIT)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .freeze_ni (freeze_ni),
    .a_halt_i  (a_halt_i),
    .a_load_i  (a_load_i),
    .b_load_i  (b_load_i),
    .wdata_i   (wdata_i),
    .a_count_o (a_count_o),
    .b_count_o (b_count_o),
    .irq_req_o (irq_req_o)
);

// File: tb/dual_interval_timer_test.sv
module dual_interval_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tclk = 1'b0;
    logic        freeze_n = 1'b1;
    logic        a_start = 1'b0, a_halt = 1'b0, a_load = 1'b0;
    logic        b_start = 1'b0, b_halt = 1'b0, b_load = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] a_count, b_count, irq;

    int checks = 0;
    int fails  = 0;
    int a_pulses = 0;
    int b_pulses = 0;

    // reference model state
    bit      hist[$];
    int      ma, mb, mpre;
    bit      ma_run, mb_run, ma_wrap, mb_wrap;

    always #10 clk = ~clk;

    dual_interval_timer uut (
        .clk_i(clk), .rst_ni(rst_n), .tclk_i(tclk), .freeze_ni(freeze_n),
        .a_start_i(a_start), .a_halt_i(a_halt), .a_load_i(a_load),
        .b_start_i(b_start), .b_halt_i(b_halt), .b_load_i(b_load),
        .wdata_i(wdata), .a_count_o(a_count), .b_count_o(b_count),
        .irq_req_o(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: rising edge sampled high at edge n steps at edge n+2.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{0, 0, 0};
            ma = 0; mb = 0; mpre = 0;
            ma_run = 0; mb_run = 0; ma_wrap = 0; mb_wrap = 0;
        end else begin
            bit q;
            bit ra, rb;
            q = hist[1] && !hist[0] && freeze_n;
            ra = ma_run; rb = mb_run;
            ma_wrap = 0; mb_wrap = 0;
            if (a_load) ma = wdata;
            else if (ra && q) begin
                ma_wrap = (ma == 16'hFFFF);
                ma = (ma + 1) % 65536;
            end
            if (b_load) begin
                mb = wdata; mpre = 0;
            end else if (rb && q) begin
                if (mpre == 9) begin
                    mpre = 0;
                    mb_wrap = (mb == 16'hFFFF);
                    mb = (mb + 1) % 65536;
                end else mpre++;
            end
            if (a_halt) ma_run = 0; else if (a_start) ma_run = 1;
            if (b_halt) mb_run = 0; else if (b_start) mb_run = 1;
            hist.push_back(tclk);
            void'(hist.pop_front());
        end
    end

    // per-cycle comparison and pulse counting, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 timer A vs model", a_count, ma);
            check("R5 timer B vs model", b_count, mb);
            check("R8 request vector vs model", irq,
                  (int'(ma_wrap) << 7) | (int'(mb_wrap) << 9));
            if (irq[7]) a_pulses++;
            if (irq[9]) b_pulses++;
        end
    end

    // which: 0 A start, 1 A halt, 2 A load, 3 B start, 4 B halt, 5 B load, 6 A start+halt
    task automatic strobe(input int which, input logic [15:0] d);
        @(negedge clk);
        wdata = d;
        case (which)
            0: a_start = 1;
            1: a_halt = 1;
            2: a_load = 1;
            3: b_start = 1;
            4: b_halt = 1;
            5: b_load = 1;
            default: begin a_start = 1; a_halt = 1; end
        endcase
        @(negedge clk);
        {a_start, a_halt, a_load, b_start, b_halt, b_load} = '0;
    endtask

    task automatic tclk_periods(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tclk = 1;
            repeat (half) @(negedge clk);
            tclk = 0;
            repeat (half - 1) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset A count", a_count, 0);
        check("R1 reset B count", b_count, 0);
        check("R1 reset request vector", irq, 0);
        tclk_periods(2, 3);
        check("R1 halted after reset A", a_count, 0);

        strobe(0, 16'h0);
        tclk_periods(7, 3);
        check("R2 A after 7 periods", a_count, 7);
        check("R5 B stays halted", b_count, 0);

        strobe(1, 16'h0);
        tclk_periods(5, 2);
        check("R3 A halted", a_count, 7);

        strobe(3, 16'h0);
        tclk_periods(25, 2);
        check("R5 B after 25 ticks", b_count, 2);
        strobe(4, 16'h0);
        tclk_periods(10, 3);
        check("R11 B halted holds", b_count, 2);
        strobe(3, 16'h0);
        tclk_periods(5, 2);
        check("R11 prescale kept across halt", b_count, 3);
        tclk_periods(4, 2);
        strobe(5, 16'hFFFF);
        check("R10 B load visible", b_count, 16'hFFFF);
        tclk_periods(9, 2);
        check("R7 prescale cleared by load", b_count, 16'hFFFF);
        check("R6 no early B wrap", b_pulses, 0);
        tclk_periods(1, 2);
        check("R6 B wraps to zero", b_count, 0);
        check("R6 single B request", b_pulses, 1);

        freeze_n = 0;
        strobe(0, 16'h0);
        tclk_periods(6, 3);
        check("R9 A frozen", a_count, 7);
        check("R9 B frozen", b_count, 0);
        freeze_n = 1;
        tclk_periods(3, 3);
        check("R9 A resumes after freeze", a_count, 10);

        strobe(2, 16'hFFFE);
        check("R10 A load visible", a_count, 16'hFFFE);
        tclk_periods(3, 5);
        check("R4 A wraps and continues", a_count, 1);
        check("R4 single A request", a_pulses, 1);
        check("R8 B no extra request", b_pulses, 1);

        strobe(6, 16'h0);
        tclk_periods(3, 3);
        check("R3 halt wins over start", a_count, 1);
        check("R5 B after 6 more ticks", b_count, 0);

        summary();
        $finish;
    end
endmodule